// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a hardware watchdog that software controls only by writing 16-bit magic values to a key register on a small memory-mapped register port. A free-running clock divider, selected by a 3-bit code, produces ticks that decrement a 12-bit down-counter. When the counter runs out while the watchdog is running, the block emits a one-cycle reset pulse and counts again from the reload value. Once started, the watchdog cannot be stopped by software. Only the block reset returns it to idle.

The divider code and the reload value are write-protected. An unlock key opens them, and any other key write closes them again. A written value does not take effect at once. It waits through a synchronization delay of a few divider ticks. During that delay a busy flag for that value is visible in the status register. The usual sequence is: unlock, write the divider code and the reload value, wait for both flags to clear, start, then refresh regularly. Refresh writes must be closer together than (reload + 1) × division clock cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider code reads 0, the reload value reads 0xFFF, the status reads 0, the watchdog is idle and `wdtReset` is low.
- R2: A write hits when `busSel` and `busWr` are high and `busAddr[1:0]` is 0. Word offsets are key 0x00, divider code 0x04 (bits 2:0), reload 0x08 (bits 11:0), status 0x0C (bit 0 divider busy, bit 1 reload busy). Writing the key 0x00005555 unlocks the divider and reload registers. While they are locked, writes to 0x04 and 0x08 leave their read-back values unchanged.
- R3: A key write of any value other than 0x00005555 locks the registers again.
- R4: An unlocked write to 0x04 or 0x08 changes the read-back value from the next cycle and raises its status bit. The bit falls after SYNC_TICKS divider ticks. Counted from the write edge, it stays high between (SYNC_TICKS−1)×div+1 and SYNC_TICKS×div cycles, where div is the division in effect.
- R5: The active divider code c gives a division of 4·2^c for c from 0 to 6. Code 7 also divides by 256.
- R6: The key 0x0000CCCC starts the watchdog and restarts the divider phase. From reset, the first pulse comes 4096×4 cycles after the start edge.
- R7: The key 0x0000AAAA loads the counter from the active reload value R and restarts the divider phase. `wdtReset` then rises exactly (R+1)×div cycles after that edge.
- R8: `wdtReset` is high for exactly one cycle. The counter then reloads and counting continues, so the next pulse follows (R+1)×div cycles later.
- R9: No key write stops a running watchdog, including 0x00000000 and unknown values.
- R10: A newly written reload value or divider code is used only after its status bit clears. A refresh issued while the update is pending loads the old value.
- R11: Reads return the value zero-extended to 32 bits. The key offset, offset 0x10 and every other unused offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low synchronous block reset |
| busSel | input | 1 | Register port select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (5) | Byte address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, combinational, 0 when not reading |
| wdtReset | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with its default parameters: a 12-bit reload, a 3-bit divider code with divisions of 4 to 256, and a sync latency of three ticks. Small reload values with every kind of division keep exact timeout and period checks short. The full-range reset value is still reached once, through the 16384-cycle first timeout after a start from reset. The three-tick latency opens a window wide enough to issue a refresh while an update is pending, and to bound how long each busy flag stays high.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;

  // word indices (byte offset / 4)
  localparam int IDX_KEY  = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_RLD  = 2;
  localparam int IDX_STAT = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic divRestart;  // restart divider phase
    logic cntLoad;     // load counter from active reload
    logic runEn;       // watchdog running
    logic divWr;       // accepted write of divider code
    logic rldWr;       // accepted write of reload value
    logic divApply;    // pending divider code takes effect
    logic rldApply;    // pending reload value takes effect
  } wdtCtl_t;

endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              tick,
  output wdtCtl_t           ctl,
  output logic [1:0]        pendFlags
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  logic [IDX_W-1:0] wordIdx;
  logic wrHit, keyWr, isOpen, isStart, isFeed;
  logic unlocked, running;
  logic [1:0] wrStb, applyStb;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrHit   = busSel && busWr && (busAddr[1:0] == 2'b00);
  assign keyWr   = wrHit && (wordIdx == IDX_W'(IDX_KEY));
  assign isOpen  = (busWdata == DATA_W'(KEY_OPEN));
  assign isStart = (busWdata == DATA_W'(KEY_START));
  assign isFeed  = (busWdata == DATA_W'(KEY_FEED));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else if (keyWr) begin
      unlocked <= isOpen;
      if (isStart) running <= 1'b1;
    end
  end

  assign wrStb[0] = wrHit && unlocked && (wordIdx == IDX_W'(IDX_DIV));
  assign wrStb[1] = wrHit && unlocked && (wordIdx == IDX_W'(IDX_RLD));

  // one synchronization channel per protected register
  for (genvar ch = 0; ch < 2; ch++) begin : g_sync
    logic              pendQ;
    logic [SYNC_W-1:0] waitQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        waitQ <= '0;
      end else if (wrStb[ch]) begin
        pendQ <= 1'b1;
        waitQ <= SYNC_W'(SYNC_TICKS);
      end else if (pendQ && tick) begin
        if (waitQ == SYNC_W'(1)) begin
          pendQ <= 1'b0;
          waitQ <= '0;
        end else begin
          waitQ <= waitQ - SYNC_W'(1);
        end
      end
    end

    assign pendFlags[ch] = pendQ;
    assign applyStb[ch]  = pendQ && tick && (waitQ == SYNC_W'(1)) && !wrStb[ch];
  end

  always_comb begin
    ctl            = '0;
    ctl.divRestart = keyWr && (isStart || isFeed);
    ctl.cntLoad    = keyWr && isFeed;
    ctl.runEn      = running;
    ctl.divWr      = wrStb[0];
    ctl.rldWr      = wrStb[1];
    ctl.divApply   = applyStb[0];
    ctl.rldApply   = applyStb[1];
  end

endmodule

// File: rtl/kwdt_dp.sv
module kwdt_dp
  import kwdt_pkg::*;
#(
  parameter int RELOAD_W  = 12,
  parameter int CODE_W    = 3,
  parameter int MAX_CODE  = 6,
  parameter int BASE_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtCtl_t             ctl,
  input  logic [CODE_W-1:0]   divIn,
  input  logic [RELOAD_W-1:0] rldIn,
  output logic                tick,
  output logic [CODE_W-1:0]   divShadow,
  output logic [RELOAD_W-1:0] rldShadow,
  output logic                wdtReset
);

  localparam int PRE_W = BASE_LOG2 + MAX_CODE;
  localparam logic [CODE_W-1:0] MAX_CODE_V = CODE_W'(MAX_CODE);

  logic [CODE_W-1:0]   divActive, effCode;
  logic [RELOAD_W-1:0] rldActive, cnt;
  logic [PRE_W-1:0]    preCnt, divMask;
  logic [PRE_W:0]      span, spanM1;
  int                  shAmt;
  logic                expire;

  // programmed and active configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divShadow <= '0;
      rldShadow <= '1;
      divActive <= '0;
      rldActive <= '1;
    end else begin
      if (ctl.divWr)    divShadow <= divIn;
      if (ctl.rldWr)    rldShadow <= rldIn;
      if (ctl.divApply) divActive <= divShadow;
      if (ctl.rldApply) rldActive <= rldShadow;
    end
  end

  // divider: tick when the low bits of the phase counter are all ones
  always_comb begin
    effCode = (divActive > MAX_CODE_V) ? MAX_CODE_V : divActive;
    shAmt   = BASE_LOG2 + int'(effCode);
    span    = (PRE_W + 1)'(1) << shAmt;
    spanM1  = span - (PRE_W + 1)'(1);
    divMask = spanM1[PRE_W-1:0];
  end

  assign tick = ((preCnt & divMask) == divMask);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.divRestart) preCnt <= '0;
    else                         preCnt <= preCnt + PRE_W'(1);
  end

  // down-counter and timeout pulse
  assign expire = ctl.runEn && tick && (cnt == '0) && !ctl.cntLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '1;
      wdtReset <= 1'b0;
    end else begin
      wdtReset <= expire;
      if (ctl.cntLoad)                cnt <= rldActive;
      else if (expire)                cnt <= rldActive;
      else if (ctl.runEn && tick)     cnt <= cnt - RELOAD_W'(1);
    end
  end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int RELOAD_W   = 12,
  parameter int CODE_W     = 3,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              wdtReset
);

  localparam int IDX_W = ADDR_W - 2;

  wdtCtl_t             ctl;
  logic                tick;
  logic [1:0]          pendFlags;
  logic [CODE_W-1:0]   divShadow;
  logic [RELOAD_W-1:0] rldShadow;

  kwdt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_TICKS(SYNC_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .tick(tick),
    .ctl(ctl), .pendFlags(pendFlags)
  );

  kwdt_dp #(
    .RELOAD_W(RELOAD_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .divIn(busWdata[CODE_W-1:0]), .rldIn(busWdata[RELOAD_W-1:0]),
    .tick(tick), .divShadow(divShadow), .rldShadow(rldShadow),
    .wdtReset(wdtReset)
  );

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr && busAddr[1:0] == 2'b00) begin
      case (busAddr[ADDR_W-1:2])
        IDX_W'(IDX_DIV):  busRdata = DATA_W'(divShadow);
        IDX_W'(IDX_RLD):  busRdata = DATA_W'(rldShadow);
        IDX_W'(IDX_STAT): busRdata = DATA_W'(pendFlags);
        default:          busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int RELOAD_W = 12,
  parameter int CODE_W   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic                wdtReset,
  input logic                running,
  input logic [1:0]          pendFlags,
  input logic [CODE_W-1:0]   divShadow,
  input logic [RELOAD_W-1:0] rldShadow
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic wrOk, keyOther, divWrite, rldWrite;

  assign idx      = busAddr[ADDR_W-1:2];
  assign wrOk     = busSel && busWr && busAddr[1:0] == 2'b00;
  assign keyOther = wrOk && idx == IDX_W'(0) && busWdata != DATA_W'(16'h5555);
  assign divWrite = wrOk && idx == IDX_W'(1);
  assign rldWrite = wrOk && idx == IDX_W'(2);

  // R2 / R3: a register write right after a locking key write is dropped
  p_locked_div_r3: assert property (@(posedge clk) disable iff (!rstN)
    keyOther ##1 divWrite |=> $stable(divShadow));
  p_locked_rld_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyOther ##1 rldWrite |=> $stable(rldShadow));

  // R4: an accepted reload write raises its busy flag
  p_flag_raise_r4: assert property (@(posedge clk) disable iff (!rstN)
    rldWrite && $past(rldShadow) != busWdata[RELOAD_W-1:0] && $changed(rldShadow) |-> pendFlags[1]);

  // R6: pulses only come from a running watchdog
  p_pulse_running_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |-> running);

  // R8: the pulse lasts one cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> !wdtReset);

  // R9: once running, stays running
  p_no_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  // R11: key offset reads zero
  p_key_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWr && idx == IDX_W'(0) |-> busRdata == '0);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_W(RELOAD_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .wdtReset(wdtReset), .running(ctl.runEn), .pendFlags(pendFlags),
  .divShadow(divShadow), .rldShadow(rldShadow)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wdtReset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdtReset(wdtReset)
  );

  // divider code, reload value
  localparam int NVEC = 6;
  localparam logic [14:0] VEC [NVEC] = '{
    {3'd0, 12'd5}, {3'd1, 12'd0}, {3'd7, 12'd1},
    {3'd6, 12'd2}, {3'd3, 12'd31}, {3'd4, 12'd9}
  };

  function automatic int period(input int code, input int rl);
    int dv;
    dv = (code > 6) ? 256 : (4 << code);
    return (rl + 1) * dv;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      finishRun();
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  // samples status bit b at each negedge; counts how long it stays high
  task automatic flagTime(input int b, input int limit, output int n);
    logic [31:0] st;
    n = 0;
    for (int j = 0; j < limit; j++) begin
      busRead(5'h0C, st);
      if (!st[b]) break;
      n++;
    end
  endtask

  // j = 0 at the negedge after the edge of the last action
  task automatic timePulse(input int limit, output int at);
    at = -1;
    for (int j = 0; j <= limit; j++) begin
      @(negedge clk);
      if (wdtReset) begin
        at = j;
        break;
      end
    end
  endtask

  initial begin
    logic [31:0] rd;
    int n, at, exp;

    // R1: reset state
    doReset();
    busRead(5'h04, rd); check(rd == 32'h0, "R1 divider reset", rd, 0);
    busRead(5'h08, rd); check(rd == 32'hFFF, "R1 reload reset", rd, 32'hFFF);
    busRead(5'h0C, rd); check(rd == 32'h0, "R1 status reset", rd, 0);
    check(wdtReset == 1'b0, "R1 pulse low", wdtReset, 0);

    // R2: locked writes ignored
    busWrite(5'h04, 32'd5);
    busWrite(5'h08, 32'h0AA);
    busRead(5'h04, rd); check(rd == 32'h0, "R2 locked divider", rd, 0);
    busRead(5'h08, rd); check(rd == 32'hFFF, "R2 locked reload", rd, 32'hFFF);
    busRead(5'h0C, rd); check(rd == 32'h0, "R2 no pending", rd, 0);

    // R3: other key relocks
    busWrite(5'h00, 32'h5555);
    busWrite(5'h00, 32'h1234);
    busWrite(5'h04, 32'd3);
    busRead(5'h04, rd); check(rd == 32'h0, "R3 relocked", rd, 0);

    // R11: key, reserved and unused offsets read zero
    busRead(5'h00, rd); check(rd == 32'h0, "R11 key reads zero", rd, 0);
    busRead(5'h10, rd); check(rd == 32'h0, "R11 offset 0x10 zero", rd, 0);
    busRead(5'h1C, rd); check(rd == 32'h0, "R11 unused offset zero", rd, 0);

    // R4: flag latency with division 4, SYNC_TICKS 3 -> 9..12 cycles
    busWrite(5'h00, 32'h5555);
    busWrite(5'h08, 32'h123);
    flagTime(1, 100, n);
    check(n >= 9 && n <= 12, "R4 reload flag time", n, 12);
    busRead(5'h08, rd); check(rd == 32'h123, "R4 reload readback", rd, 32'h123);
    busWrite(5'h04, 32'd2);
    flagTime(0, 100, n);
    check(n >= 9 && n <= 12, "R4 divider flag time", n, 12);
    busRead(5'h04, rd); check(rd == 32'h2, "R4 divider readback", rd, 2);

    // R5 / R7 / R8: table of divider codes and reload values
    for (int v = 0; v < NVEC; v++) begin
      int code, rl, p;
      code = int'(VEC[v][14:12]);
      rl   = int'(VEC[v][11:0]);
      p    = period(code, rl);
      doReset();
      busWrite(5'h00, 32'h5555);
      busWrite(5'h04, 32'(code));
      busWrite(5'h08, 32'(rl));
      flagTime(0, 2000, n);
      flagTime(1, 2000, n);
      busRead(5'h0C, rd); check(rd == 32'h0, "R4 flags cleared", rd, 0);
      busWrite(5'h00, 32'hCCCC);
      busWrite(5'h00, 32'hAAAA);
      timePulse(p + 10, at);
      check(at == p, "R7/R5 first timeout", at, p);
      timePulse(p + 10, at);
      check(at == p - 1, "R8 reload period", at, p - 1);
    end

    // R6 / R9: start from reset, stop attempts ignored
    doReset();
    busWrite(5'h00, 32'hCCCC);
    busWrite(5'h00, 32'h0000);
    busWrite(5'h00, 32'h1234);
    exp = 4096 * 4 - 2;
    timePulse(exp + 10, at);
    check(at == exp, "R6/R9 start from reset", at, exp);

    // R10: refresh while update pending uses old reload
    doReset();
    busWrite(5'h00, 32'h5555);
    busWrite(5'h08, 32'd5);
    flagTime(1, 200, n);
    busWrite(5'h00, 32'hCCCC);
    busWrite(5'h00, 32'h5555);
    busWrite(5'h08, 32'd9);
    busWrite(5'h00, 32'hAAAA);
    timePulse(100, at);
    check(at == 24, "R10 old reload used", at, 24);
    timePulse(100, at);
    check(at == 39, "R10 new reload after apply", at, 39);

    finishRun();
  end

endmodule